// File: doc/BRIEF.md
# Multi-Lane Transmit Alignment Sequencer

This controller prepares a group of serial transmit lanes for low-skew operation. One start request runs a fixed three-phase sequence. First, it walks the lanes in ascending order. On each lane's dynamic reconfiguration port it reads a configuration word and writes it back with a single low-latency bit set. Second, it emits a train of one-cycle alignment-sync pulses on a line shared by all lanes. The pulses are timed by the sequencer clock, which acts as the synchronization clock. Third, it hands a reset request into the lanes' user-clock domain. There the request becomes one shared PCS reset pulse of fixed length. When that pulse has finished, the sequencer reports done.

Each reconfiguration access is a request/ready exchange, not a stream. The sequencer raises the lane's enable for one cycle, with write-enable high for a write. It then waits for that lane's ready strobe, and returns read data are taken in the cycle ready is high. No ready strobe can be withheld to apply back-pressure. If ready stays away too long, the sequencer stops, raises an error flag together with done, and issues no sync pulse and no reset. All other pins are plain levels.

Top module: `tx_align_seq`

## Requirements
- R1: While reset is applied and right after its release, `drp_en`, `drp_we`, `sync_o`, `pcs_rst`, `done` and `err` are all low.
- R2: A start pulse is accepted only while the sequencer is idle or done. A start pulse that arrives during a running sequence has no effect: each lane still sees exactly one read and one write, and exactly `NUM_PULSES` sync pulses are issued.
- R3: Lanes are configured one at a time in ascending index order. For each lane there is one read, then one write, both at address `CFG_ADDR` (default 0x43). At most one bit of `drp_en` is high in any cycle.
- R4: The write data equals the word returned by that lane's read with bit `CFG_BIT` (default 7) forced to 1. No other bit and no other register of any lane changes.
- R5: If the addressed lane's ready does not arrive within `RDY_TIMEOUT` (default 64) waiting cycles, `err` and `done` rise. For the read case, `done` first appears `RDY_TIMEOUT`+1 cycles after the cycle in which the read enable was seen. No further access, no sync pulse and no reset follow.
- R6: After the last lane's write, `sync_o` carries exactly `NUM_PULSES` pulses. Each pulse is one clock cycle wide, and consecutive rising edges are exactly `PULSE_SPACING` cycles apart (at least 4).
- R7: `sync_o` is low before `pcs_rst` rises, and `pcs_rst` follows the last sync pulse.
- R8: `pcs_rst` is driven from the `usr_clk` domain through a two-flop synchronizer. It appears once per sequence and is high for exactly `RST_CYCLES` (default 3) consecutive `usr_clk` cycles.
- R9: After a successful sequence, `done` rises with `err` low. Both then hold, with no further port activity, until the next start.
- R10: A start while done reruns the complete sequence and clears `err` left by a timed-out run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer and synchronization clock |
| rst_n | input | 1 | Active-low reset, `clk` domain |
| start | input | 1 | One-cycle request to run the sequence |
| drp_en | output | LANES | Per-lane reconfiguration access strobe |
| drp_we | output | LANES | Per-lane write qualifier for `drp_en` |
| drp_addr | output | AW | Reconfiguration address, shared by all lanes |
| drp_di | output | DW | Write data, shared by all lanes |
| drp_do | input | LANES*DW | Per-lane read data, lane i at bits [i*DW +: DW] |
| drp_rdy | input | LANES | Per-lane access-complete strobe |
| sync_o | output | 1 | Alignment-sync line shared by all lanes |
| usr_clk | input | 1 | Lanes' user clock |
| usr_rst_n | input | 1 | Active-low reset, `usr_clk` domain |
| pcs_rst | output | 1 | Shared PCS reset, `usr_clk` domain |
| done | output | 1 | Sequence finished, held until next start |
| err | output | 1 | Ready timeout occurred in the last sequence |

## Verification
The bench builds the sequencer with four lanes, three sync pulses and a spacing of five. With the default single pulse the gap state is never entered, so these values bring it into play and expose every spacing interval. The register-file responder answers with random latency, and `usr_clk` runs at a period unrelated to `clk`, so the reset handshake is exercised across a true clock boundary. Stalling one interior lane reaches the timeout path, and the run after it shows that a start issued while done recovers from the error.

// File: rtl/tx_align_pkg.sv
package tx_align_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRP_READ,
    ST_DRP_WRITE,
    ST_SYNC_PULSE,
    ST_SYNC_GAP,
    ST_RESET,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/tx_align_cycle_timer.sv
// Saturating up-counter with synchronous clear; measures waits and gaps.
module tx_align_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clear)          count <= '0;
    else if (count != '1)    count <= count + 1'b1;
  end
endmodule

// File: rtl/tx_align_rst_bridge.sv
// Toggle handshake: a request toggle crosses into usr_clk, becomes a fixed
// length pulse there, and an acknowledge toggle crosses back.
module tx_align_rst_bridge #(
  parameter int RST_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_tgl,
  output logic ack_seen,
  input  logic usr_clk,
  input  logic usr_rst_n,
  output logic pcs_rst
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic       req_s1, req_s2, req_s3;
  logic [CW-1:0] len_cnt;
  logic       ack_tgl;
  logic       ack_s1, ack_s2;

  always_ff @(posedge usr_clk or negedge usr_rst_n) begin
    if (!usr_rst_n) begin
      req_s1  <= 1'b0;
      req_s2  <= 1'b0;
      req_s3  <= 1'b0;
      len_cnt <= '0;
      pcs_rst <= 1'b0;
      ack_tgl <= 1'b0;
    end else begin
      req_s1 <= req_tgl;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
      if (req_s2 ^ req_s3) begin
        len_cnt <= CW'(RST_CYCLES);
        pcs_rst <= 1'b1;
      end else if (len_cnt != '0) begin
        len_cnt <= len_cnt - 1'b1;
        pcs_rst <= (len_cnt != CW'(1));
        if (len_cnt == CW'(1)) ack_tgl <= req_s3;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_tgl;
      ack_s2 <= ack_s1;
    end
  end

  assign ack_seen = ack_s2;
endmodule

// File: rtl/tx_align_seq.sv
module tx_align_seq
  import tx_align_pkg::*;
#(
  parameter int            LANES         = 2,
  parameter int            AW            = 7,
  parameter int            DW            = 16,
  parameter logic [AW-1:0] CFG_ADDR      = 7'h43,
  parameter int            CFG_BIT       = 7,
  parameter int            NUM_PULSES    = 1,
  parameter int            PULSE_SPACING = 4,
  parameter int            RDY_TIMEOUT   = 64,
  parameter int            RST_CYCLES    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic [LANES-1:0]    drp_en,
  output logic [LANES-1:0]    drp_we,
  output logic [AW-1:0]       drp_addr,
  output logic [DW-1:0]       drp_di,
  input  logic [LANES*DW-1:0] drp_do,
  input  logic [LANES-1:0]    drp_rdy,
  output logic                sync_o,
  input  logic                usr_clk,
  input  logic                usr_rst_n,
  output logic                pcs_rst,
  output logic                done,
  output logic                err
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int PCNT_W = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;
  localparam int TMO_W  = $clog2(RDY_TIMEOUT);
  localparam int GAP_W  = $clog2(PULSE_SPACING);

  seq_state_e        state;
  logic [LANE_W-1:0] lane;
  logic              issue;
  logic [DW-1:0]     rd_word;
  logic [PCNT_W-1:0] pulse_cnt;
  logic              req_tgl;
  logic              ack_seen;
  logic [TMO_W-1:0]  wait_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic              in_access;
  logic              lane_rdy;
  logic [DW-1:0]     lane_do;
  logic              timed_out;

  assign in_access = (state == ST_DRP_READ) || (state == ST_DRP_WRITE);
  assign lane_rdy  = drp_rdy[lane];
  assign lane_do   = drp_do[int'(lane)*DW +: DW];
  assign timed_out = (wait_cnt == TMO_W'(RDY_TIMEOUT - 1));

  tx_align_cycle_timer #(.W(TMO_W)) u_wait_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (issue || !in_access),
    .count (wait_cnt)
  );

  tx_align_cycle_timer #(.W(GAP_W)) u_gap_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state != ST_SYNC_GAP),
    .count (gap_cnt)
  );

  tx_align_rst_bridge #(.RST_CYCLES(RST_CYCLES)) u_rst_bridge (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_tgl   (req_tgl),
    .ack_seen  (ack_seen),
    .usr_clk   (usr_clk),
    .usr_rst_n (usr_rst_n),
    .pcs_rst   (pcs_rst)
  );

  // Per-lane strobes: only the current lane, only in the issue cycle.
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane_strobe
      assign drp_en[g] = issue && in_access && (lane == LANE_W'(g));
      assign drp_we[g] = issue && (state == ST_DRP_WRITE) && (lane == LANE_W'(g));
    end
  endgenerate

  assign drp_addr = CFG_ADDR;
  assign drp_di   = rd_word | (DW'(1) << CFG_BIT);
  assign sync_o   = (state == ST_SYNC_PULSE);
  assign done     = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lane      <= '0;
      issue     <= 1'b0;
      rd_word   <= '0;
      pulse_cnt <= '0;
      req_tgl   <= 1'b0;
      err       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state <= ST_DRP_READ;
            lane  <= '0;
            issue <= 1'b1;
            err   <= 1'b0;
          end
        end
        ST_DRP_READ: begin
          if (issue) begin
            issue <= 1'b0;
          end else if (lane_rdy) begin
            rd_word <= lane_do;
            state   <= ST_DRP_WRITE;
            issue   <= 1'b1;
          end else if (timed_out) begin
            err   <= 1'b1;
            state <= ST_DONE;
          end
        end
        ST_DRP_WRITE: begin
          if (issue) begin
            issue <= 1'b0;
          end else if (lane_rdy) begin
            if (lane == LANE_W'(LANES - 1)) begin
              state     <= ST_SYNC_PULSE;
              pulse_cnt <= '0;
            end else begin
              lane  <= lane + 1'b1;
              state <= ST_DRP_READ;
              issue <= 1'b1;
            end
          end else if (timed_out) begin
            err   <= 1'b1;
            state <= ST_DONE;
          end
        end
        ST_SYNC_PULSE: begin
          pulse_cnt <= pulse_cnt + 1'b1;
          if (pulse_cnt == PCNT_W'(NUM_PULSES - 1)) begin
            state   <= ST_RESET;
            req_tgl <= ~req_tgl;
          end else begin
            state <= ST_SYNC_GAP;
          end
        end
        ST_SYNC_GAP: begin
          if (gap_cnt == GAP_W'(PULSE_SPACING - 2)) state <= ST_SYNC_PULSE;
        end
        ST_RESET: begin
          if (ack_seen == req_tgl) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_align_seq_chk.sv
module tx_align_seq_chk #(
  parameter int LANES         = 2,
  parameter int DW            = 16,
  parameter int CFG_BIT       = 7,
  parameter int PULSE_SPACING = 4,
  parameter int RST_CYCLES    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             usr_clk,
  input logic             usr_rst_n,
  input logic [LANES-1:0] drp_en,
  input logic [LANES-1:0] drp_we,
  input logic [DW-1:0]    drp_di,
  input logic             sync_o,
  input logic             pcs_rst,
  input logic             done,
  input logic             err
);
  logic [15:0] low_run;
  logic        seen_sync;
  logic [7:0]  rst_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run   <= '0;
      seen_sync <= 1'b0;
    end else begin
      if (sync_o) begin
        low_run   <= '0;
        seen_sync <= 1'b1;
      end else if (low_run != 16'hFFFF) begin
        low_run <= low_run + 1'b1;
      end
    end
  end

  always_ff @(posedge usr_clk or negedge usr_rst_n) begin
    if (!usr_rst_n)   rst_run <= '0;
    else if (pcs_rst) rst_run <= rst_run + 1'b1;
    else              rst_run <= '0;
  end

  p_en_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drp_en));

  p_wr_bit_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(drp_en & drp_we)) |-> drp_di[CFG_BIT]);

  p_sync_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);

  p_sync_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && seen_sync) |-> (low_run >= 16'(PULSE_SPACING - 1)));

  p_rst_len_r8: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    $fell(pcs_rst) |-> (rst_run == 8'(RST_CYCLES)));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sync_o && (drp_en == '0)));

  p_err_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind tx_align_seq tx_align_seq_chk #(
  .LANES(LANES), .DW(DW), .CFG_BIT(CFG_BIT),
  .PULSE_SPACING(PULSE_SPACING), .RST_CYCLES(RST_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .usr_clk(usr_clk), .usr_rst_n(usr_rst_n),
  .drp_en(drp_en), .drp_we(drp_we), .drp_di(drp_di), .sync_o(sync_o),
  .pcs_rst(pcs_rst), .done(done), .err(err)
);

// File: tb/tx_align_seq_tb_top.sv
module tx_align_seq_tb_top;
  localparam int LANES = 4;
  localparam int AW    = 7;
  localparam int DW    = 16;
  localparam int NP    = 3;
  localparam int SP    = 5;
  localparam int TMO   = 64;
  localparam int RSTC  = 3;
  localparam int ADDR  = 'h43;
  localparam int BITN  = 7;

  logic                clk = 0, usr_clk = 0;
  logic                rst_n = 0, usr_rst_n = 0;
  logic                start = 0;
  logic [LANES-1:0]    drp_en, drp_we, drp_rdy;
  logic [AW-1:0]       drp_addr;
  logic [DW-1:0]       drp_di;
  logic [LANES*DW-1:0] drp_do;
  logic                sync_o, pcs_rst, done, err;

  always #4 clk = ~clk;
  always #3 usr_clk = ~usr_clk;

  tx_align_seq #(
    .LANES(LANES), .AW(AW), .DW(DW), .CFG_ADDR(7'h43), .CFG_BIT(BITN),
    .NUM_PULSES(NP), .PULSE_SPACING(SP), .RDY_TIMEOUT(TMO), .RST_CYCLES(RSTC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .drp_en(drp_en), .drp_we(drp_we),
    .drp_addr(drp_addr), .drp_di(drp_di), .drp_do(drp_do), .drp_rdy(drp_rdy),
    .sync_o(sync_o), .usr_clk(usr_clk), .usr_rst_n(usr_rst_n),
    .pcs_rst(pcs_rst), .done(done), .err(err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [DW-1:0] mem  [LANES][128];
  logic [DW-1:0] expm [LANES][128];
  int  busy [LANES], lat [LANES], rd_cnt [LANES], wr_cnt [LANES];
  logic          p_we [LANES];
  logic [AW-1:0] p_addr [LANES];
  logic [DW-1:0] p_di [LANES];
  int  rd_order [$];
  int  stall_lane = -1;
  int  cyc = 0, addr_bad = 0;
  int  sync_cnt = 0, gap_bad = 0, width_bad = 0, last_sync = -1;
  int  stall_en_cyc = -1, done_cyc = -1;
  bit  prev_sync = 0, prev_done = 0;
  time last_sync_t = 0, rst_rise_t = 0;
  int  rst_run = 0, rst_pulses = 0, rst_len_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Lane register-file responders and sync monitor, all on one negedge.
  always @(negedge clk) begin
    cyc++;
    for (int l = 0; l < LANES; l++) begin
      drp_rdy[l] = 1'b0;
      if (busy[l] != 0) begin
        if (lat[l] == 1) begin
          if (p_we[l]) mem[l][p_addr[l]] = p_di[l];
          else drp_do[l*DW +: DW] = mem[l][p_addr[l]];
          drp_rdy[l] = 1'b1;
          busy[l] = 0;
        end else lat[l]--;
      end else if (drp_en[l]) begin
        if (drp_addr != AW'(ADDR)) addr_bad++;
        if (drp_we[l]) wr_cnt[l]++;
        else begin rd_cnt[l]++; rd_order.push_back(l); end
        if (l == stall_lane) stall_en_cyc = cyc;
        else begin
          busy[l] = 1; lat[l] = 1 + int'($urandom % 4);
          p_we[l] = drp_we[l]; p_addr[l] = drp_addr; p_di[l] = drp_di;
        end
      end
    end
    if (sync_o) begin
      sync_cnt++;
      if (prev_sync) width_bad++;
      else if (last_sync >= 0 && cyc - last_sync != SP) gap_bad++;
      last_sync = cyc;
    end
    if (prev_sync && !sync_o) last_sync_t = $time;
    prev_sync = sync_o;
    if (done && !prev_done) done_cyc = cyc;
    prev_done = done;
  end

  always @(negedge usr_clk) begin
    if (pcs_rst) begin
      if (rst_run == 0) rst_rise_t = $time;
      rst_run++;
    end else if (rst_run > 0) begin
      rst_pulses++;
      if (rst_run != RSTC) rst_len_bad++;
      rst_run = 0;
    end
  end

  task automatic run_seq(input int stall);
    int waited;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      rd_cnt[l] = 0; wr_cnt[l] = 0;
      for (int a = 0; a < 128; a++) begin
        mem[l][a] = DW'($urandom);
        expm[l][a] = mem[l][a];
      end
    end
    rd_order.delete();
    stall_lane = stall; stall_en_cyc = -1; done_cyc = -1;
    sync_cnt = 0; gap_bad = 0; width_bad = 0; last_sync = -1; addr_bad = 0;
    rst_pulses = 0; rst_len_bad = 0;
    for (int l = 0; l < LANES; l++)
      if (stall < 0 || l < stall) expm[l][ADDR][BITN] = 1'b1;
    start = 1; @(negedge clk); start = 0;
    waited = 0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
      if (!done && ($urandom % 12) == 0) begin  // R2: start while busy
        start = 1; @(negedge clk); start = 0; waited++;
      end
    end
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R9 done held", int'(done), 1);
    chk(addr_bad == 0, "R3 address", addr_bad, 0);
    for (int l = 0; l < LANES; l++)
      for (int a = 0; a < 128; a++)
        if (mem[l][a] !== expm[l][a])
          chk(0, "R4 register content", int'(mem[l][a]), int'(expm[l][a]));
    chk(1, "R4 register content", 0, 0);
    if (stall < 0) begin
      chk(err == 1'b0, "R9 err low", int'(err), 0);
      chk(rd_order.size() == LANES, "R2 read count", rd_order.size(), LANES);
      for (int l = 0; l < LANES; l++) begin
        chk(l < rd_order.size() && rd_order[l] == l, "R3 lane order",
            (l < rd_order.size()) ? rd_order[l] : -1, l);
        chk(wr_cnt[l] == 1, "R2 write count", wr_cnt[l], 1);
      end
      chk(sync_cnt == NP, "R6 pulse count", sync_cnt, NP);
      chk(gap_bad == 0 && width_bad == 0, "R6 spacing/width", gap_bad + width_bad, 0);
      chk(rst_pulses == 1 && rst_len_bad == 0, "R8 reset pulse", rst_pulses * 10 + rst_len_bad, 10);
      chk(rst_rise_t > last_sync_t, "R7 sync low before reset",
          int'(rst_rise_t / 1000), int'(last_sync_t / 1000) + 1);
    end else begin
      chk(err == 1'b1, "R5 err set", int'(err), 1);
      chk(done_cyc - stall_en_cyc == TMO + 1, "R5 timeout cycles", done_cyc - stall_en_cyc, TMO + 1);
      chk(sync_cnt == 0, "R5 no sync", sync_cnt, 0);
      chk(rst_pulses == 0, "R5 no reset", rst_pulses, 0);
      chk(wr_cnt[stall] == 0, "R5 no write to stalled lane", wr_cnt[stall], 0);
      chk(rd_cnt[LANES-1] == 0, "R5 no later lane", rd_cnt[LANES-1], 0);
    end
    stall_lane = -1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    drp_rdy = '0; drp_do = '0;
    for (int l = 0; l < LANES; l++) begin busy[l] = 0; lat[l] = 0; end
    repeat (6) @(negedge clk);
    // R1: reset state, during and after reset
    chk({drp_en, drp_we, sync_o, pcs_rst, done, err} == '0, "R1 in reset", 0, 0);
    rst_n = 1; usr_rst_n = 1;
    repeat (3) @(negedge clk);
    chk(drp_en == '0 && drp_we == '0, "R1 drp idle", int'(drp_en), 0);
    chk(!sync_o && !pcs_rst && !done && !err, "R1 outputs low",
        int'({sync_o, pcs_rst, done, err}), 0);
    run_seq(-1);          // from idle
    run_seq(-1);          // R10 restart from done
    run_seq(2);           // stall interior lane
    run_seq(-1);          // R10 recovery clears err
    chk(err == 1'b0, "R10 err cleared", int'(err), 0);
    for (int k = 0; k < 3; k++) run_seq(-1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule